// File: doc/BRIEF.md
# Programmable Carry-Chain Logic Unit

This block evaluates, in a single pass over a word, a small cluster of integer operations that has been folded into one step: any mix of bitwise logic on up to four operand words, combined with at most one addition or subtraction. Each bit position is handled the same way. Two small truth tables turn that position's operand bits into a generate bit and a propagate bit. A carry network then gives every position its incoming carry. A third truth table mixes the position's operand bits with that carry to form the result bit.

Software or a control unit loads the three truth tables and a carry-in bit through a register-write port. It then pulses `start` with the operand words. The operands are captured on that edge. The result register and a one-cycle `done` pulse follow on the next edge. Configuration writes are dropped while an operation is being accepted or is in flight, so an operation always uses one consistent configuration. A parameter chooses between a logarithmic-depth prefix carry network and a serial ripple network.

Top module: `lut_carry_unit`

## Requirements
- R1: After reset, `busy`, `done` and `result` are 0 and all truth tables and the carry-in bit are 0, so an operation started before any configuration write yields 0.
- R2: When `start` is sampled high, `busy` is high in the following cycle, and on the next edge `result` is loaded and `done` is high for that one cycle.
- R3: The generate and propagate tables are indexed per bit position by {in4,in3,in2,in1}, with in1 as the least significant index bit. Operand k (k = 1..4) sits at `operands[(k-1)*WIDTH +: WIDTH]`.
- R4: The carry into bit i (i > 0) is the prefix combination of bits 0..i-1 and the carry-in under (G,P) o (G',P') = (G | P&G', P&P'). With generate = in1&in2, propagate = in1^in2 and output = propagate^carry, the result is (in1+in2) mod 2^WIDTH.
- R5: The carry-in bit supplies the carry into bit 0. Generate = in1&~in2, propagate = ~(in1^in2) and carry-in 1 give (in1-in2) mod 2^WIDTH. With the add tables, carry-in 1 gives in1+in2+1.
- R6: The output table is indexed by {carry, in4, in3, in2, in1}. With zero generate and propagate tables, the output table 0xF666F666 produces (in1^in2)|(in3&in4) in every bit.
- R7: An add and a logic step fold together: with the add generate and propagate tables, an output table for propagate^carry^in3 gives (in1+in2)^in3.
- R8: A configuration write in a cycle where `start` or `busy` is high has no effect.
- R9: `cfg_sel` picks the target: 0 loads the generate table from `cfg_wdata[15:0]`, 1 loads the propagate table from `cfg_wdata[15:0]`, 2 loads the output table from `cfg_wdata[31:0]`, and 3 loads the carry-in bit from `cfg_wdata[0]`.
- R10: `result` holds its value in every cycle without `done`, and `done` stays low in any cycle that does not follow a `busy` cycle.
- R11: Starts on consecutive cycles each produce their own result, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Operation start strobe; operands are captured on this edge |
| operands | input | 128 | Four operand words, operand 1 in the lowest 32 bits |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Result loaded this cycle |
| result | output | 32 | Registered result word |

## Verification
The bench uses an 8-bit instance. For every value of the first operand, it pairs sixteen second-operand values chosen to span the range, so that long carry propagation, no carries and wrap-around all occur. It runs the same sweep under five configurations: plain add, add with carry-in 1, subtract, the four-input logic function, and an add folded with an XOR. The add and subtract sweeps exercise the prefix combination and the carry-in. The logic sweep shows that the output table alone decides the result once the carry is held at zero. The folded case shows that the carry reaches the output table as its top index bit. The bench also issues writes during the start cycle and the busy cycle, and then shows that the configuration in effect is unchanged.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

   typedef enum logic [1:0] {
      SEL_GEN  = 2'd0,
      SEL_PROP = 2'd1,
      SEL_OUT  = 2'd2,
      SEL_CIN  = 2'd3
   } cfg_sel_e;

   // Group combine: upper segment (g_hi,p_hi) over lower segment (g_lo,p_lo).
   // Returns {group_generate, group_propagate}.
   function automatic logic [1:0] gp_merge(input logic g_hi, input logic p_hi,
                                           input logic g_lo, input logic p_lo);
      return {g_hi | (p_hi & g_lo), p_hi & p_lo};
   endfunction

endpackage

// File: rtl/lcu_cfg_regs.sv
module lcu_cfg_regs #(
   parameter int GP_BITS  = 16,
   parameter int OUT_BITS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          sel,
   input  logic [OUT_BITS-1:0] wdata,
   input  logic                lock,
   output logic [GP_BITS-1:0]  gen_tab,
   output logic [GP_BITS-1:0]  prop_tab,
   output logic [OUT_BITS-1:0] out_tab,
   output logic                cin
);
   import lcu_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_tab  <= '0;
         prop_tab <= '0;
         out_tab  <= '0;
         cin      <= 1'b0;
      end else if (we && !lock) begin
         case (cfg_sel_e'(sel))
            SEL_GEN:  gen_tab  <= wdata[GP_BITS-1:0];
            SEL_PROP: prop_tab <= wdata[GP_BITS-1:0];
            SEL_OUT:  out_tab  <= wdata;
            SEL_CIN:  cin      <= wdata[0];
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/lcu_gp_luts.sv
module lcu_gp_luts #(
   parameter int WIDTH   = 32,
   parameter int NUM_IN  = 4,
   localparam int GP_BITS = 1 << NUM_IN
) (
   input  logic [NUM_IN*WIDTH-1:0] ops,
   input  logic [GP_BITS-1:0]      gen_tab,
   input  logic [GP_BITS-1:0]      prop_tab,
   output logic [WIDTH-1:0]        g,
   output logic [WIDTH-1:0]        p
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      wire [NUM_IN-1:0] idx;
      for (genvar k = 0; k < NUM_IN; k++) begin : g_in
         assign idx[k] = ops[k*WIDTH + b];
      end
      assign g[b] = gen_tab[idx];
      assign p[b] = prop_tab[idx];
   end

endmodule

// File: rtl/lcu_carry_net.sv
module lcu_carry_net #(
   parameter int WIDTH      = 32,
   parameter bit USE_PREFIX = 1'b1,
   localparam int LEVELS    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] g,
   input  logic [WIDTH-1:0] p,
   input  logic             cin,
   output logic [WIDTH:0]   carry   // carry[i] enters bit i; carry[WIDTH] leaves the top
);
   import lcu_pkg::*;

   if (USE_PREFIX) begin : g_prefix
      wire [LEVELS:0][WIDTH-1:0]   gl;
      wire [LEVELS-1:0][WIDTH-1:0] pl;

      // level 0: fold the carry-in into position 0
      assign gl[0][0] = g[0] | (p[0] & cin);
      assign pl[0][0] = p[0];
      for (genvar i = 1; i < WIDTH; i++) begin : g_l0
         assign gl[0][i] = g[i];
         assign pl[0][i] = p[i];
      end

      for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
         localparam int DIST = 1 << lv;
         for (genvar i = 0; i < WIDTH; i++) begin : g_pos
            if (i < DIST) begin : g_pass
               assign gl[lv+1][i] = gl[lv][i];
               if (lv < LEVELS-1) begin : g_pp
                  assign pl[lv+1][i] = pl[lv][i];
               end
            end else begin : g_merge
               wire [1:0] m;
               assign m = gp_merge(gl[lv][i], pl[lv][i], gl[lv][i-DIST], pl[lv][i-DIST]);
               assign gl[lv+1][i] = m[1];
               if (lv < LEVELS-1) begin : g_pm
                  assign pl[lv+1][i] = m[0];
               end
            end
         end
      end

      assign carry[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_out
         assign carry[i+1] = gl[LEVELS][i];
      end
   end else begin : g_ripple
      wire [WIDTH:0] rc;
      assign rc[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign rc[i+1] = g[i] | (p[i] & rc[i]);
      end
      assign carry = rc;
   end

endmodule

// File: rtl/lcu_out_lut.sv
module lcu_out_lut #(
   parameter int WIDTH    = 32,
   parameter int NUM_IN   = 4,
   localparam int OUT_BITS = 1 << (NUM_IN + 1)
) (
   input  logic [NUM_IN*WIDTH-1:0] ops,
   input  logic [WIDTH-1:0]        carry,
   input  logic [OUT_BITS-1:0]     out_tab,
   output logic [WIDTH-1:0]        res
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      wire [NUM_IN:0] idx;
      assign idx[NUM_IN] = carry[b];
      for (genvar k = 0; k < NUM_IN; k++) begin : g_in
         assign idx[k] = ops[k*WIDTH + b];
      end
      assign res[b] = out_tab[idx];
   end

endmodule

// File: rtl/lut_carry_unit.sv
module lut_carry_unit #(
   parameter int WIDTH      = 32,
   parameter int NUM_IN     = 4,
   parameter bit USE_PREFIX = 1'b1,
   localparam int GP_BITS   = 1 << NUM_IN,
   localparam int OUT_BITS  = 1 << (NUM_IN + 1),
   localparam int OPS_W     = NUM_IN * WIDTH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [OUT_BITS-1:0] cfg_wdata,
   input  logic                start,
   input  logic [OPS_W-1:0]    operands,
   output logic                busy,
   output logic                done,
   output logic [WIDTH-1:0]    result
);

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("lut_carry_unit: WIDTH must be a power of two, at least 4");
   end
   if (NUM_IN < 2 || NUM_IN > 5) begin : g_bad_inputs
      $error("lut_carry_unit: NUM_IN must lie in 2..5");
   end

   logic [GP_BITS-1:0]  gen_tab;
   logic [GP_BITS-1:0]  prop_tab;
   logic [OUT_BITS-1:0] out_tab;
   logic                cfg_cin;
   logic [OPS_W-1:0]    ops_q;
   logic [WIDTH-1:0]    g_w;
   logic [WIDTH-1:0]    p_w;
   logic [WIDTH:0]      carry_w;
   logic [WIDTH-1:0]    res_w;
   logic                unused_cout;

   lcu_cfg_regs #(.GP_BITS(GP_BITS), .OUT_BITS(OUT_BITS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .sel      (cfg_sel),
      .wdata    (cfg_wdata),
      .lock     (start | busy),
      .gen_tab  (gen_tab),
      .prop_tab (prop_tab),
      .out_tab  (out_tab),
      .cin      (cfg_cin)
   );

   // operand capture stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ops_q <= '0;
         busy  <= 1'b0;
      end else begin
         busy <= start;
         if (start) ops_q <= operands;
      end
   end

   lcu_gp_luts #(.WIDTH(WIDTH), .NUM_IN(NUM_IN)) u_gp (
      .ops      (ops_q),
      .gen_tab  (gen_tab),
      .prop_tab (prop_tab),
      .g        (g_w),
      .p        (p_w)
   );

   lcu_carry_net #(.WIDTH(WIDTH), .USE_PREFIX(USE_PREFIX)) u_net (
      .g     (g_w),
      .p     (p_w),
      .cin   (cfg_cin),
      .carry (carry_w)
   );

   assign unused_cout = carry_w[WIDTH];

   lcu_out_lut #(.WIDTH(WIDTH), .NUM_IN(NUM_IN)) u_out (
      .ops     (ops_q),
      .carry   (carry_w[WIDTH-1:0]),
      .out_tab (out_tab),
      .res     (res_w)
   );

   // result stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= busy;
         if (busy) result <= res_w;
      end
   end

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
   parameter int WIDTH    = 32,
   parameter int GP_BITS  = 16,
   parameter int OUT_BITS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                done,
   input logic [WIDTH-1:0]    result,
   input logic [GP_BITS-1:0]  gen_tab,
   input logic [GP_BITS-1:0]  prop_tab,
   input logic [OUT_BITS-1:0] out_tab,
   input logic                cfg_cin
);

   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> done);

   assert_done_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start || busy) |=> ($stable(gen_tab) && $stable(prop_tab)
                           && $stable(out_tab) && $stable(cfg_cin)));

endmodule

bind lut_carry_unit lcu_checker #(
   .WIDTH(WIDTH), .GP_BITS(GP_BITS), .OUT_BITS(OUT_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .result   (result),
   .gen_tab  (gen_tab),
   .prop_tab (prop_tab),
   .out_tab  (out_tab),
   .cfg_cin  (cfg_cin)
);

// File: tb/lut_carry_unit_test.sv
`timescale 1ns/1ps
module lut_carry_unit_test;

   localparam int W = 8;
   localparam int N = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_sel = '0;
   logic [31:0]     cfg_wdata = '0;
   logic            start = 1'b0;
   logic [N*W-1:0]  operands = '0;
   logic            busy;
   logic            done;
   logic [W-1:0]    result;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;   // 250 MHz

   lut_carry_unit #(.WIDTH(W), .NUM_IN(N), .USE_PREFIX(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .start(start), .operands(operands),
      .busy(busy), .done(done), .result(result)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // table builders, indexed {carry,in4,in3,in2,in1}
   function automatic logic [15:0] tab_gp(input int kind);
      logic [15:0] t;
      for (int v = 0; v < 16; v++) begin
         case (kind)
            0: t[v] = v[0] & v[1];        // add generate
            1: t[v] = v[0] ^ v[1];        // add propagate
            2: t[v] = v[0] & ~v[1];       // subtract generate
            3: t[v] = ~(v[0] ^ v[1]);     // subtract propagate
            default: t[v] = 1'b0;
         endcase
      end
      return t;
   endfunction

   function automatic logic [31:0] tab_out(input int kind);
      logic [31:0] t;
      for (int v = 0; v < 32; v++) begin
         case (kind)
            0: t[v] = v[0] ^ v[1] ^ v[4];          // add
            1: t[v] = ~(v[0] ^ v[1]) ^ v[4];       // subtract
            2: t[v] = v[0] ^ v[1] ^ v[4] ^ v[2];   // add then xor in3
            default: t[v] = 1'b0;
         endcase
      end
      return t;
   endfunction

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic [W-1:0] d,
                         input logic [W-1:0] exp, input string req);
      @(negedge clk);
      operands = {d, c, b, a};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2 busy", 32'(busy), 32'd1);
      @(negedge clk);
      check(done == 1'b1, "R2 done", 32'(done), 32'd1);
      check(result == exp, req, 32'(result), 32'(exp));
   endtask

   // mode: 0 add, 1 add+cin, 2 sub, 3 logic, 4 add^in3
   task automatic sweep(input int mode, input string req);
      for (int a = 0; a < 256; a++) begin
         for (int j = 0; j < 16; j++) begin
            logic [W-1:0] av, bv, cv, dv, ev;
            av = W'(a);
            bv = W'((j * 17) ^ (a >> 3) ^ ((j & 1) ? 8'hFF : 8'h00));
            cv = W'(a * 5 + j * 29);
            dv = W'(a ^ (j * 73));
            case (mode)
               0: ev = av + bv;
               1: ev = av + bv + 8'd1;
               2: ev = av - bv;
               3: ev = (av ^ bv) | (cv & dv);
               default: ev = (av + bv) ^ cv;
            endcase
            run_op(av, bv, cv, dv, ev, req);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
      check(done == 1'b0, "R1 done", 32'(done), 32'd0);
      check(result == '0, "R1 result", 32'(result), 32'd0);
      run_op(8'hA5, 8'h3C, 8'hFF, 8'h0F, 8'h00, "R1 cleared tables");

      // R3 R4 R9 plain add
      cfg_write(2'd0, 32'(tab_gp(0)));
      cfg_write(2'd1, 32'(tab_gp(1)));
      cfg_write(2'd2, tab_out(0));
      cfg_write(2'd3, 32'd0);
      run_op(8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, "R4 full carry ripple");
      sweep(0, "R4 add");

      // R5 add with carry-in
      cfg_write(2'd3, 32'd1);
      run_op(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, "R5 cin through all bits");
      sweep(1, "R5 add plus cin");

      // R5 subtract
      cfg_write(2'd0, 32'(tab_gp(2)));
      cfg_write(2'd1, 32'(tab_gp(3)));
      cfg_write(2'd2, tab_out(1));
      run_op(8'h00, 8'h01, 8'h00, 8'h00, 8'hFF, "R5 borrow wrap");
      sweep(2, "R5 subtract");

      // R6 logic only, R3 operand order
      cfg_write(2'd0, 32'd0);
      cfg_write(2'd1, 32'd0);
      cfg_write(2'd2, 32'hF666F666);
      cfg_write(2'd3, 32'd0);
      run_op(8'h00, 8'h00, 8'hF0, 8'h3C, 8'h30, "R3 in3 in4 order");
      sweep(3, "R6 logic table");

      // R7 folded add and xor
      cfg_write(2'd0, 32'(tab_gp(0)));
      cfg_write(2'd1, 32'(tab_gp(1)));
      cfg_write(2'd2, tab_out(2));
      sweep(4, "R7 add xor in3");

      // R8 writes during start and busy are dropped
      cfg_write(2'd2, tab_out(0));
      @(negedge clk);
      operands = {8'h00, 8'h00, 8'h27, 8'h1D};
      start = 1'b1;
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'd0;
      @(negedge clk);
      start = 1'b0;
      cfg_sel = 2'd3; cfg_wdata = 32'd1;
      @(negedge clk);
      cfg_we = 1'b0;
      check(result == 8'h44, "R8 op during writes", 32'(result), 32'h44);
      run_op(8'h80, 8'h80, 8'h00, 8'h00, 8'h00, "R8 config kept");
      run_op(8'h0F, 8'h01, 8'h00, 8'h00, 8'h10, "R8 config kept");

      // R10 hold
      held = result;
      repeat (3) begin
         @(negedge clk);
         check(done == 1'b0, "R10 done low", 32'(done), 32'd0);
         check(result == held, "R10 hold", 32'(result), 32'(held));
      end

      // R11 back-to-back starts
      @(negedge clk);
      operands = {8'h00, 8'h00, 8'h02, 8'h03};
      start = 1'b1;
      @(negedge clk);
      operands = {8'h00, 8'h00, 8'h10, 8'hF0};
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R11 first done", 32'(done), 32'd1);
      check(result == 8'h05, "R11 first", 32'(result), 32'h05);
      @(negedge clk);
      check(done == 1'b1, "R11 second done", 32'(done), 32'd1);
      check(result == 8'h00, "R11 second", 32'(result), 32'h00);
      @(negedge clk);
      check(done == 1'b0, "R11 idle", 32'(done), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule